// File: doc/BRIEF.md
# Coin-Accumulating Vending Controller

This block is a small processor that keeps a running sum of deposited coins and raises a one-cycle dispense pulse when that sum reaches an item price supplied at run time. It is split into two parts: a state machine that sequences the sale, and a datapath that holds the running sum, adds coins to it and compares it with the price. The two parts exchange only three signals: a load command, a clear command and a "sum below price" status bit.

A coin appears as a one-cycle strobe, and its value is valid in that same cycle. The sum saturates at its largest value, so it never wraps. After the pulse, the controller clears the sum and waits for the next sale. Change return and coin checking are handled elsewhere.

Top module: `vend_top`

## Requirements
- R1: A synchronous active-high `rst` puts the controller in its clearing state, sets the sum to zero and holds `dispense` low. On the first edge after `rst` falls, the controller enters its waiting state.
- R2: In the waiting state, a `coin_strobe` high for one cycle is accepted. `coin_value` is captured at that edge. On the next edge the sum becomes old sum plus coin, and the controller returns to waiting.
- R3: The sum saturates at 2^W-1 (255 by default) instead of wrapping. For example, 200 + 200 gives 255, which meets a price of 255.
- R4: In the waiting state with no strobe, the controller stays put while sum < `price` (unsigned). When sum >= `price`, it moves to the dispense state on the next edge.
- R5: `dispense` is registered. It goes high in the cycle after the waiting cycle that met the price and stays high for exactly one clock cycle.
- R6: After the dispense cycle, the controller spends one cycle clearing, so the next sale starts from zero.
- R7: A strobe in the waiting state takes priority over the price check. A coin that arrives while the price is already met is added first, and the pulse follows two cycles later.
- R8: A strobe seen in the adding, dispense or clearing state is ignored and leaves the sum unchanged.
- R9: `price` is sampled live, so a change while waiting takes effect in the very next comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coin_strobe | input | 1 | One-cycle pulse marking a deposited coin |
| coin_value | input | 8 | Value of the coin, valid with the strobe |
| price | input | 8 | Item price, unsigned |
| dispense | output | 1 | One-cycle pulse ordering an item out |

## Verification
The bench drives inputs on the falling edge and samples on the falling edge after the rising edge that matters. Timing follows from an accepted strobe at edge k:
- The sum is updated at edge k+1.
- If the price is then met, `dispense` rises at edge k+2 and falls at edge k+3.
- The cleared sum is in place at edge k+4.

Every check lands at one of those offsets. While a coin is in flight, the bench also samples `dispense` low in the intermediate cycles. This shows that the priority rule and the ignored strobes held, rather than only seeing the final result.

// File: rtl/vend_pkg.sv
package vend_pkg;

    localparam int VALUE_W = 8;

    typedef enum logic [1:0] {
        ST_CLEAR = 2'd0,
        ST_IDLE  = 2'd1,
        ST_SUM   = 2'd2,
        ST_GIVE  = 2'd3
    } vend_state_e;

    typedef struct packed {
        logic load;
        logic clear;
    } sum_ctrl_t;

    function automatic logic [VALUE_W-1:0] sat_add(input logic [VALUE_W-1:0] a,
                                                  input logic [VALUE_W-1:0] b);
        logic [VALUE_W:0] wide;
        wide = {1'b0, a} + {1'b0, b};
        return wide[VALUE_W] ? {VALUE_W{1'b1}} : wide[VALUE_W-1:0];
    endfunction

endpackage

// File: rtl/vend_datapath.sv
module vend_datapath
    import vend_pkg::*;
#(
    parameter int W = VALUE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  sum_ctrl_t    ctrl,
    input  logic         coin_strobe,
    input  logic [W-1:0] coin_value,
    input  logic [W-1:0] price,
    output logic         sum_lt_price,
    output logic [W-1:0] sum_q
);
    localparam logic [W-1:0] SUM_MAX = {W{1'b1}};

    logic [W-1:0] coin_q;
    logic [W:0]   wide_sum;
    logic [W-1:0] next_sum;

    // Coin value latched on every strobe; only consumed when the FSM loads.
    always_ff @(posedge clk) begin
        if (rst)              coin_q <= '0;
        else if (coin_strobe) coin_q <= coin_value;
    end

    always_comb begin
        wide_sum = {1'b0, sum_q} + {1'b0, coin_q};
        next_sum = wide_sum[W] ? SUM_MAX : wide_sum[W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst || ctrl.clear) sum_q <= '0;
        else if (ctrl.load)    sum_q <= next_sum;
    end

    assign sum_lt_price = (sum_q < price);

endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
    import vend_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        coin_strobe,
    input  logic        sum_lt_price,
    output sum_ctrl_t   ctrl,
    output vend_state_e state_q,
    output logic        dispense_q
);
    vend_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR: state_d = ST_IDLE;
            ST_IDLE: begin
                if (coin_strobe)        state_d = ST_SUM;
                else if (!sum_lt_price) state_d = ST_GIVE;
            end
            ST_SUM:   state_d = ST_IDLE;
            ST_GIVE:  state_d = ST_CLEAR;
            default:  state_d = ST_CLEAR;
        endcase
    end

    always_comb begin
        ctrl.load  = (state_q == ST_SUM);
        ctrl.clear = (state_q == ST_CLEAR);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_CLEAR;
            dispense_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            dispense_q <= (state_d == ST_GIVE);
        end
    end

endmodule

// File: rtl/vend_top.sv
module vend_top
    import vend_pkg::*;
#(
    parameter int W = VALUE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         coin_strobe,
    input  logic [W-1:0] coin_value,
    input  logic [W-1:0] price,
    output logic         dispense
);
    sum_ctrl_t   ctrl;
    vend_state_e state_q;
    logic        sum_lt_price;
    logic [W-1:0] sum_q;

    vend_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .coin_strobe  (coin_strobe),
        .sum_lt_price (sum_lt_price),
        .ctrl         (ctrl),
        .state_q      (state_q),
        .dispense_q   (dispense)
    );

    vend_datapath #(.W(W)) u_dp (
        .clk          (clk),
        .rst          (rst),
        .ctrl         (ctrl),
        .coin_strobe  (coin_strobe),
        .coin_value   (coin_value),
        .price        (price),
        .sum_lt_price (sum_lt_price),
        .sum_q        (sum_q)
    );

endmodule

// File: rtl/vend_chk.sv
module vend_chk
    import vend_pkg::*;
#(
    parameter int W = VALUE_W
) (
    input logic         clk,
    input logic         rst,
    input logic         coin_strobe,
    input logic [W-1:0] price,
    input logic         dispense,
    input vend_state_e  state_q,
    input logic [W-1:0] sum_q
);
    logic rst_seen;
    always_ff @(posedge clk) rst_seen <= rst;

    // R1: one edge after reset, the controller is clearing and idle at the output
    always @(posedge clk) begin
        if (rst_seen) begin
            assert_reset_state_R1: assert (state_q == ST_CLEAR && !dispense && sum_q == '0);
        end
    end

    assert_one_cycle_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        dispense |=> !dispense);

    assert_clear_after_give_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_GIVE) |=> (state_q == ST_CLEAR));

    assert_no_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SUM) |=> (sum_q >= $past(sum_q)));

    assert_coin_first_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && coin_strobe) |=> (state_q == ST_SUM && !dispense));

    assert_ignore_sum_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SUM) |=> (state_q == ST_IDLE));

    assert_wait_holds_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !coin_strobe && sum_q < price) |=> (state_q == ST_IDLE && !dispense));

    assert_give_when_met_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !coin_strobe && sum_q >= price) |=> dispense);

endmodule

bind vend_top vend_chk #(.W(W)) u_vend_chk (
    .clk         (clk),
    .rst         (rst),
    .coin_strobe (coin_strobe),
    .price       (price),
    .dispense    (dispense),
    .state_q     (state_q),
    .sum_q       (sum_q)
);

// File: tb/tb_vend_top.sv
`timescale 1ns/1ps
module tb_vend_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         coin_strobe = 1'b0;
    logic [W-1:0] coin_value = '0;
    logic [W-1:0] price = 8'd1;
    logic         dispense;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    vend_top dut (
        .clk         (clk),
        .rst         (rst),
        .coin_strobe (coin_strobe),
        .coin_value  (coin_value),
        .price       (price),
        .dispense    (dispense)
    );

    function automatic int sat(input int a, input int b);
        return (a + b > 255) ? 255 : a + b;
    endfunction

    task automatic chk(input bit actual, input bit expected, input string req);
        checks++;
        if (actual !== expected) begin
            fails++;
            $display("FAIL %s: dispense=%0b expected %0b at %0t", req, actual, expected, $time);
        end
    endtask

    // Entered just after a falling edge with the controller in reset.
    task automatic do_reset();
        rst = 1'b1; coin_strobe = 1'b0;
        @(negedge clk); @(negedge clk);
        chk(dispense, 1'b0, "R1 dispense low in reset");
        rst = 1'b0;
        @(negedge clk);
    endtask

    // Entered in the waiting state; leaves in the waiting state with sum updated.
    task automatic coin(input int v);
        coin_strobe = 1'b1; coin_value = v[W-1:0];
        @(negedge clk);
        coin_strobe = 1'b0;
        chk(dispense, 1'b0, "R2 no pulse while adding");
        @(negedge clk);
        chk(dispense, 1'b0, "R2 waiting after add");
    endtask

    // Waiting with sum >= price: pulse, then clearing, then waiting.
    task automatic expect_sale(input string req);
        @(negedge clk);
        chk(dispense, 1'b1, req);
        @(negedge clk);
        chk(dispense, 1'b0, "R5 pulse one cycle");
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: run hung, actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int tot;
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();

        // R1 / R4: zero sum below price stays waiting
        price = 8'd10;
        @(negedge clk); chk(dispense, 1'b0, "R4 stay while below price");

        // R2 / R4 basic sale
        coin(5);
        @(negedge clk); chk(dispense, 1'b0, "R4 sum 5 below 10");
        coin(5);
        expect_sale("R4 sum 10 meets price");
        // R6 cleared: one coin of 5 must not reach 10
        coin(5);
        @(negedge clk); chk(dispense, 1'b0, "R6 sum restarted from zero");
        coin(5);
        expect_sale("R6 second sale");

        // R8 strobe during adding ignored
        coin_strobe = 1'b1; coin_value = 8'd5;
        @(negedge clk);               // adding, strobe still high
        coin_value = 8'd9;
        @(negedge clk);               // back to waiting
        coin_strobe = 1'b0;
        chk(dispense, 1'b0, "R8 strobe in add ignored");
        @(negedge clk); chk(dispense, 1'b0, "R8 sum still 5");
        coin(5);
        expect_sale("R8 sale after ignored strobe");

        // R8 strobes during dispense and clearing ignored
        price = 8'd30;
        coin(30);
        @(negedge clk); chk(dispense, 1'b1, "R4 sale at 30");
        coin_strobe = 1'b1; coin_value = 8'd200;   // seen in dispense cycle
        @(negedge clk);
        chk(dispense, 1'b0, "R5 pulse ended");      // clearing, strobe still high
        @(negedge clk);
        coin_strobe = 1'b0;
        price = 8'd50;
        chk(dispense, 1'b0, "R8 strobe in give/clear ignored");
        coin(10);
        @(negedge clk); chk(dispense, 1'b0, "R8 sum is 10 not 210");
        @(negedge clk); chk(dispense, 1'b0, "R8 sum still below 50");

        // R9 lower price live
        price = 8'd10;
        expect_sale("R9 price drop takes effect");

        // R7 coin priority when price already met
        price = 8'd20;
        coin(10);
        price = 8'd5;
        coin_strobe = 1'b1; coin_value = 8'd3;
        @(negedge clk);
        coin_strobe = 1'b0;
        chk(dispense, 1'b0, "R7 coin taken before dispense");
        @(negedge clk); chk(dispense, 1'b0, "R7 add completes first");
        expect_sale("R7 dispense after added coin");

        // R3 saturation
        price = 8'd255;
        coin(200);
        coin(200);
        expect_sale("R3 sum saturates at 255");

        // R1 mid-sale reset clears the sum
        price = 8'd40;
        coin(30);
        do_reset();
        coin(30);
        @(negedge clk); chk(dispense, 1'b0, "R1 reset cleared partial sum");
        coin(10);
        expect_sale("R1 sale after reset");

        // Random sales
        for (int s = 0; s < 60; s++) begin
            price = 8'(1 + ($urandom % 255));
            tot = 0;
            while (tot < int'(price)) begin
                int v;
                v = 1 + ($urandom % 80);
                coin(v);
                tot = sat(tot, v);
                if (tot < int'(price)) begin
                    @(negedge clk); chk(dispense, 1'b0, "R4 random below price");
                end
            end
            expect_sale("R2 random sale");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule